// File: doc/BRIEF.md
# CIC and Compensation FIR Decimation Chain

This block reduces the sample rate of the two rails (I and Q) of a digital down-converter by a factor of 2·R. Each rail has its own chain. A cascaded integrator-comb decimator cuts the converter-rate stream by the rate factor R, which defaults to 50 and may be set to other values such as 300. A compensating FIR then flattens the passband droop that the CIC causes and halves the rate again. With a 10 MS/s input and R = 50, the CIC output runs at 200 kS/s and the final output at 100 kS/s.

The FIR uses a single multiplier and accumulator per rail. It keeps a history of the most recent CIC outputs. On every second CIC output it walks through that history one tap per clock. The chain keeps the full CIC bit growth and carries it into the multiply. The accumulator is rescaled with an arithmetic right shift that is a parameter, and the result saturates to the output width.

The two rails share one input strobe and one set of coefficients. They hold no state in common, so one rail's data never affects the other.

Top module: `cic_cfir_decim_pair`

## Requirements
- R1: The clock is synchronous and the reset is active high. Reset clears every integrator, comb delay, history entry and counter, and holds both output strobes low and both outputs at zero. After reset, no output strobe appears until at least TAPS·R valid input samples have been taken.
- R2: Each rail's CIC has 4 integrator and 4 comb stages with a differential delay of 1. It emits one value on every R-th valid input: samples R, 2R, 3R and so on, counted from 1 after reset. That value equals four cascaded length-R running sums of the input, taken at the current sample.
- R3: The integrators are IN_W + 4·ceil(log2 R) bits wide and wrap modulo 2^width. Integrator overflow in a long run therefore does not corrupt the CIC output.
- R4: The FIR computes y = Σ c[k]·v[k] for k = 0..TAPS-1. Here v[0] is the newest CIC value and c[k] is bits [k·COEF_W +: COEF_W] of the coefficient vector. It produces one result for every second CIC value, starting at the TAPS-th CIC value after reset.
- R5: Each rail has one multiplier, which takes TAPS sequential multiply-accumulate cycles per result. Each output strobe is high for exactly one clock, and the output value holds between strobes.
- R6: The output is the accumulator shifted right arithmetically by OUT_SHIFT. It saturates to the most positive or most negative OUT_W-bit two's-complement value.
- R7: When the input strobe is low, the input data has no effect on any later output.
- R8: The I and Q rails are independent: each rail's outputs depend only on its own input.
- R9: When a DC input x has been applied long enough to fill the history, the output equals sat((x·R^4·Σc) >>> OUT_SHIFT).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe, shared by both rails |
| in_i | input | IN_W | Signed I-rail input sample |
| in_q | input | IN_W | Signed Q-rail input sample |
| out_valid_i | output | 1 | One-cycle strobe marking a new I result |
| out_i | output | OUT_W | Signed, rescaled I result |
| out_valid_q | output | 1 | One-cycle strobe marking a new Q result |
| out_q | output | OUT_W | Signed, rescaled Q result |

## Verification
The bench runs a long stretch of random input with random strobe gaps, so the integrators wrap many times. A design that clipped the integrators or sized them too narrowly would then give wrong results, even though the CIC output itself never overflows. Every result is compared with an independent model built from cascaded running sums and a direct convolution. That comparison catches a wrong decimation phase, a reversed coefficient order, or a FIR that fires on odd CIC outputs or before the history is full.

Directed DC runs check the full gain, and they drive each rail into opposite saturation limits. A shift of the wrong sign, or a wrap instead of a clamp, would give a wildly wrong value. An impulse run mixes garbage data into cycles where the strobe is low and keeps the Q rail at zero. Any leakage of unstrobed data, or any crosstalk between the rails, would then show up as a nonzero or shifted response.

// File: rtl/cic_cfir_pkg.sv
package cic_cfir_pkg;

  // Bit width of the integrators: input width plus the worst-case growth of
  // the cascaded integrator-comb section (differential delay of one).
  function automatic int cic_width(input int in_w, input int stages, input int rate);
    return in_w + stages * $clog2(rate);
  endfunction

  // Accumulator width: full product plus growth over the summed taps.
  function automatic int acc_width(input int data_w, input int coef_w, input int taps);
    return data_w + coef_w + $clog2(taps);
  endfunction

endpackage

// File: rtl/cic_decim.sv
module cic_decim #(
  parameter int IN_W   = 12,
  parameter int STAGES = 4,
  parameter int RATE   = 50,
  parameter int CIC_W  = 36
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    cic_valid,
  output logic signed [CIC_W-1:0] cic_data
);
  localparam int CNT_W = $clog2(RATE);

  logic signed [CIC_W-1:0] integ_q    [STAGES];
  logic signed [CIC_W-1:0] integ_d    [STAGES];
  logic signed [CIC_W-1:0] comb_dly_q [STAGES];
  logic signed [CIC_W-1:0] comb_d     [STAGES];
  logic [CNT_W-1:0]        dec_cnt_q;
  logic                    dec_strobe;
  logic                    cic_valid_q;
  logic signed [CIC_W-1:0] cic_data_q;
  logic signed [CIC_W-1:0] in_ext;

  assign in_ext     = {{(CIC_W-IN_W){in_data[IN_W-1]}}, in_data};
  assign dec_strobe = in_valid && (dec_cnt_q == CNT_W'(RATE-1));

  // Integrator chain: each stage adds the already-updated value of the stage
  // before it, so the state after a sample is the exact cumulative sum.
  always_comb begin
    integ_d[0] = integ_q[0] + in_ext;
    for (int k = 1; k < STAGES; k++) integ_d[k] = integ_q[k] + integ_d[k-1];
  end

  // Comb chain evaluated only when the decimated strobe is active.
  always_comb begin
    comb_d[0] = integ_d[STAGES-1] - comb_dly_q[0];
    for (int k = 1; k < STAGES; k++) comb_d[k] = comb_d[k-1] - comb_dly_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) begin
        integ_q[k]    <= '0;
        comb_dly_q[k] <= '0;
      end
      dec_cnt_q   <= '0;
      cic_valid_q <= 1'b0;
      cic_data_q  <= '0;
    end else begin
      cic_valid_q <= dec_strobe;
      if (in_valid) begin
        for (int k = 0; k < STAGES; k++) integ_q[k] <= integ_d[k];
        dec_cnt_q <= dec_strobe ? '0 : dec_cnt_q + 1'b1;
      end
      if (dec_strobe) begin
        comb_dly_q[0] <= integ_d[STAGES-1];
        for (int k = 1; k < STAGES; k++) comb_dly_q[k] <= comb_d[k-1];
        cic_data_q <= comb_d[STAGES-1];
      end
    end
  end

  assign cic_valid = cic_valid_q;
  assign cic_data  = cic_data_q;

  AST_IDLE_HOLDS_INTEG: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(integ_q[0]));                                         // R7
  AST_DEC_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    dec_cnt_q < CNT_W'(RATE));                                                  // R2
  AST_CIC_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    cic_valid |-> $past(in_valid));                                             // R2

endmodule

// File: rtl/cfir_mac.sv
module cfir_mac #(
  parameter int DATA_W    = 36,
  parameter int TAPS      = 96,
  parameter int COEF_W    = 16,
  parameter logic [TAPS*COEF_W-1:0] COEFS = '0,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 26,
  parameter int ACC_W     = 59
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_data,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_data
);
  localparam int PTR_W  = $clog2(TAPS);
  localparam int FILL_W = $clog2(TAPS+1);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam logic signed [ACC_W-1:0] OUT_MAX = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] OUT_MIN = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(TAPS-1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic signed [COEF_W-1:0] coef_at(input logic [PTR_W-1:0] idx);
    return COEFS[idx*COEF_W +: COEF_W];
  endfunction

  function automatic logic signed [OUT_W-1:0] rescale(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] s;
    s = a >>> OUT_SHIFT;
    if (s > OUT_MAX)      return OUT_MAX[OUT_W-1:0];
    else if (s < OUT_MIN) return OUT_MIN[OUT_W-1:0];
    else                  return s[OUT_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] hist_q [TAPS];
  logic [PTR_W-1:0]         wr_ptr_q, rd_ptr_q, step_q;
  logic [FILL_W-1:0]        fill_q;
  logic                     phase_q, busy_q;
  logic signed [ACC_W-1:0]  acc_q, acc_next;
  logic signed [PROD_W-1:0] prod;
  logic signed [COEF_W-1:0] tap_coef;
  logic                     mac_start, mac_last;
  logic                     out_valid_q;
  logic signed [OUT_W-1:0]  out_data_q;

  assign mac_start = smp_valid && phase_q && (fill_q >= FILL_W'(TAPS-1));
  assign mac_last  = busy_q && (step_q == PTR_W'(TAPS-1));
  // Oldest sample first, paired with the highest coefficient index.
  assign tap_coef  = coef_at(PTR_W'(TAPS-1) - step_q);
  assign prod      = tap_coef * hist_q[rd_ptr_q];
  assign acc_next  = acc_q + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) hist_q[k] <= '0;
      wr_ptr_q    <= '0;
      rd_ptr_q    <= '0;
      step_q      <= '0;
      fill_q      <= '0;
      phase_q     <= 1'b0;
      busy_q      <= 1'b0;
      acc_q       <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      if (smp_valid) begin
        hist_q[wr_ptr_q] <= smp_data;
        wr_ptr_q         <= ptr_next(wr_ptr_q);
        phase_q          <= ~phase_q;
        if (fill_q != FILL_W'(TAPS)) fill_q <= fill_q + 1'b1;
      end
      if (mac_start) begin
        busy_q   <= 1'b1;
        step_q   <= '0;
        rd_ptr_q <= ptr_next(wr_ptr_q);
        acc_q    <= '0;
      end else if (busy_q) begin
        acc_q    <= acc_next;
        step_q   <= step_q + 1'b1;
        rd_ptr_q <= ptr_next(rd_ptr_q);
        if (mac_last) busy_q <= 1'b0;
      end
      out_valid_q <= mac_last;
      if (mac_last) out_data_q <= rescale(acc_next);
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

  AST_MAC_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    mac_start |-> !busy_q);                                                     // R5
  AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    out_valid_q |=> !out_valid_q);                                              // R5
  AST_OUT_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
    out_valid_q |-> (fill_q == FILL_W'(TAPS)));                                 // R1
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !out_valid_q |-> $stable(out_data_q));                                      // R5

endmodule

// File: rtl/cic_cfir_decim_pair.sv
module cic_cfir_decim_pair #(
  parameter int IN_W      = 12,
  parameter int STAGES    = 4,
  parameter int RATE      = 50,
  parameter int TAPS      = 96,
  parameter int COEF_W    = 16,
  parameter logic [TAPS*COEF_W-1:0] COEFS = {TAPS{{{(COEF_W-1){1'b0}}, 1'b1}}},
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 26
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_i,
  input  logic signed [IN_W-1:0]  in_q,
  output logic                    out_valid_i,
  output logic signed [OUT_W-1:0] out_i,
  output logic                    out_valid_q,
  output logic signed [OUT_W-1:0] out_q
);
  localparam int CIC_W   = cic_cfir_pkg::cic_width(IN_W, STAGES, RATE);
  localparam int ACC_W   = cic_cfir_pkg::acc_width(CIC_W, COEF_W, TAPS);
  localparam int N_RAILS = 2;

  logic signed [IN_W-1:0]  rail_in    [N_RAILS];
  logic                    rail_cic_v [N_RAILS];
  logic signed [CIC_W-1:0] rail_cic   [N_RAILS];
  logic                    rail_out_v [N_RAILS];
  logic signed [OUT_W-1:0] rail_out   [N_RAILS];

  assign rail_in[0] = in_i;
  assign rail_in[1] = in_q;

  for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
    cic_decim #(
      .IN_W(IN_W), .STAGES(STAGES), .RATE(RATE), .CIC_W(CIC_W)
    ) u_cic (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(rail_in[r]),
      .cic_valid(rail_cic_v[r]), .cic_data(rail_cic[r])
    );

    cfir_mac #(
      .DATA_W(CIC_W), .TAPS(TAPS), .COEF_W(COEF_W), .COEFS(COEFS),
      .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT), .ACC_W(ACC_W)
    ) u_fir (
      .clk(clk), .rst(rst), .smp_valid(rail_cic_v[r]), .smp_data(rail_cic[r]),
      .out_valid(rail_out_v[r]), .out_data(rail_out[r])
    );
  end

  assign out_valid_i = rail_out_v[0];
  assign out_i       = rail_out[0];
  assign out_valid_q = rail_out_v[1];
  assign out_q       = rail_out[1];

  AST_RAILS_IN_STEP: assert property (@(posedge clk) disable iff (rst)
    out_valid_i == out_valid_q);                                                // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid_i && !out_valid_q && out_i == '0 && out_q == '0));      // R1

endmodule

// File: tb/cic_cfir_decim_pair_tb_top.sv
module cic_cfir_decim_pair_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W   = 12;
  localparam int RATE   = 50;
  localparam int TAPS   = 96;
  localparam int COEF_W = 16;
  localparam int OUT_W  = 16;
  localparam int SHIFT  = 30;
  localparam int STG    = 4;

  function automatic longint coef_of(input int k);
    return longint'(((k * 73 + 11) % 201) - 60);
  endfunction

  function automatic logic [TAPS*COEF_W-1:0] make_coefs();
    logic [TAPS*COEF_W-1:0] v;
    v = '0;
    for (int k = 0; k < TAPS; k++) v[k*COEF_W +: COEF_W] = COEF_W'(coef_of(k));
    return v;
  endfunction

  localparam logic [TAPS*COEF_W-1:0] TB_COEFS = make_coefs();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_i = '0, in_q = '0;
  logic out_valid_i, out_valid_q;
  logic signed [OUT_W-1:0] out_i, out_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  cic_cfir_decim_pair #(
    .IN_W(IN_W), .STAGES(STG), .RATE(RATE), .TAPS(TAPS), .COEF_W(COEF_W),
    .COEFS(TB_COEFS), .OUT_W(OUT_W), .OUT_SHIFT(SHIFT)
  ) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid_i(out_valid_i), .out_i(out_i), .out_valid_q(out_valid_q), .out_q(out_q)
  );

  int n_checks = 0, n_fail = 0, cycles = 0, n_valid = 0;
  string tag_i = "R4", tag_q = "R4";

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  // Independent model: cascaded running sums, then direct convolution.
  longint box_buf [2][STG][RATE];
  longint box_sum [2][STG];
  longint chist   [2][TAPS];
  int     box_ptr, dec_cnt, ccount;
  longint expq [2][$];

  function automatic longint sat_shift(input longint a);
    longint v;
    v = a >>> SHIFT;
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_reset();
    for (int r = 0; r < 2; r++) begin
      for (int s = 0; s < STG; s++) begin
        box_sum[r][s] = 0;
        for (int j = 0; j < RATE; j++) box_buf[r][s][j] = 0;
      end
      for (int k = 0; k < TAPS; k++) chist[r][k] = 0;
      expq[r].delete();
    end
    box_ptr = 0; dec_cnt = 0; ccount = 0;
  endtask

  task automatic model_push(input longint xi, input longint xq);
    longint cv [2];
    for (int r = 0; r < 2; r++) begin
      longint s;
      s = (r == 0) ? xi : xq;
      for (int k = 0; k < STG; k++) begin
        box_sum[r][k] += s - box_buf[r][k][box_ptr];
        box_buf[r][k][box_ptr] = s;
        s = box_sum[r][k];
      end
      cv[r] = s;
    end
    box_ptr = (box_ptr + 1) % RATE;
    dec_cnt++;
    if (dec_cnt == RATE) begin
      dec_cnt = 0;
      ccount++;
      for (int r = 0; r < 2; r++) begin
        for (int k = TAPS-1; k > 0; k--) chist[r][k] = chist[r][k-1];
        chist[r][0] = cv[r];
      end
      if (ccount >= TAPS && (ccount % 2) == 0) begin
        for (int r = 0; r < 2; r++) begin
          longint acc;
          acc = 0;
          for (int k = 0; k < TAPS; k++) acc += coef_of(k) * chist[r][k];
          expq[r].push_back(sat_shift(acc));
        end
      end
    end
  endtask

  function automatic longint dc_expect(input longint x);
    longint g, sc;
    g = 1; sc = 0;
    for (int s = 0; s < STG; s++) g *= RATE;
    for (int k = 0; k < TAPS; k++) sc += coef_of(k);
    return sat_shift(x * g * sc);
  endfunction

  task automatic drive(input bit v, input logic signed [IN_W-1:0] xi, input logic signed [IN_W-1:0] xq);
    @(negedge clk);
    in_valid = v; in_i = xi; in_q = xq;
    if (v) begin
      n_valid++;
      model_push(longint'(xi), longint'(xq));
    end
  endtask

  task automatic do_reset(input bit check_outputs);
    @(negedge clk);
    rst = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      in_valid = 1'b1; in_i = IN_W'($urandom); in_q = IN_W'($urandom);
      if (check_outputs && c > 0) begin
        check("R1", longint'(out_valid_i), 0);
        check("R1", longint'(out_i), 0);
        check("R1", longint'(out_q), 0);
      end
    end
    model_reset();
    n_valid = 0;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b0;
  endtask

  task automatic drain();
    for (int c = 0; c < 300; c++) drive(1'b0, '0, '0);
    check("R4", longint'(expq[0].size()), 0);
    check("R4", longint'(expq[1].size()), 0);
  endtask

  // Output monitor.
  bit prev_v [2];
  bit seen_first;
  longint last_out [2];

  always @(negedge clk) begin
    if (rst) begin
      prev_v[0] = 1'b0; prev_v[1] = 1'b0; seen_first = 1'b0;
    end else begin
      for (int r = 0; r < 2; r++) begin
        bit v;
        longint o, e;
        v = (r == 0) ? out_valid_i : out_valid_q;
        o = (r == 0) ? longint'(out_i) : longint'(out_q);
        if (v) begin
          check("R5", longint'(prev_v[r]), 0);
          if (!seen_first) begin
            seen_first = 1'b1;
            check("R1", (n_valid >= TAPS*RATE) ? 1 : 0, 1);
          end
          e = (expq[r].size() > 0) ? expq[r].pop_front() : -999999;
          check((r == 0) ? tag_i : tag_q, o, e);
          last_out[r] = o;
        end
        prev_v[r] = v;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();

    // Reset state (R1).
    do_reset(1'b1);

    // Random data with strobe gaps; long run makes the integrators wrap (R3).
    tag_i = "R2"; tag_q = "R3";
    while (n_valid < TAPS*RATE + 24*2*RATE) begin
      bit v;
      v = ($urandom_range(0, 3) != 0);
      drive(v, IN_W'($urandom), IN_W'($urandom));
    end
    drain();

    // DC: I mid-scale (R9), Q at negative full scale (R6).
    do_reset(1'b0);
    tag_i = "R9"; tag_q = "R6";
    for (int n = 0; n < 110*RATE; n++) drive(1'b1, 12'sd1000, -12'sd2048);
    drain();
    check("R9", last_out[0], dc_expect(1000));
    check("R6", last_out[1], -32768);
    check("R6", dc_expect(-2048), -32768);

    // DC: I at positive full scale (R6), Q idle (R8).
    do_reset(1'b0);
    tag_i = "R6"; tag_q = "R8";
    for (int n = 0; n < 110*RATE; n++) drive(1'b1, 12'sd2047, 12'sd0);
    drain();
    check("R6", last_out[0], 32767);
    check("R8", last_out[1], 0);

    // Impulse on I with garbage in unstrobed cycles (R7), Q zero (R8).
    do_reset(1'b0);
    tag_i = "R7"; tag_q = "R8";
    drive(1'b1, 12'sd1000, 12'sd0);
    while (n_valid < 104*2*RATE) begin
      if ($urandom_range(0, 2) == 0) drive(1'b0, IN_W'($urandom), IN_W'($urandom));
      else drive(1'b1, 12'sd0, 12'sd0);
    end
    drain();
    check("R7", last_out[0], 0);
    check("R8", last_out[1], 0);

    finish_run();
  end

endmodule